// File: doc/BRIEF.md
# Oversampled Manchester Run-Length Classifier

This block receives a one-bit hard-decision Manchester line and samples it with a clock about sixteen times faster than the bit rate. The number of samples per bit does not need to be a whole number. Each mid-bit edge carries the data: a rising edge is a one and a falling edge is a zero. Between two line transitions the level therefore lasts either half a bit or a full bit. The block measures how many consecutive equal samples make up each run. When the run ends, it sorts the run into one of four symbols: a short or long low, or a short or long high.

Every line transition produces a one-cycle tick. A downstream bit-recovery stage advances only on that tick and reads the symbol code and the short/long flag. Four threshold inputs set two inclusive windows, one for short runs and one for long runs. A register block is expected to drive these inputs. A run that falls outside both windows produces no symbol and sets a sticky error flag.

The symbol output cannot be back-pressured. Runs arrive at line rate and the block has nowhere to hold them. For this reason the output is a plain valid strobe with no ready signal, and a consumer must accept a symbol in the cycle it is strobed.

Top module: `manchester_run_classifier`

## Requirements
- R1: The line passes through two synchroniser flops. A change of `line_in` captured at clock edge n shows on `edge_tick` after clock edge n+2.
- R2: `edge_tick` is high for exactly one cycle for each transition of the synchronised line, and is low otherwise.
- R3: A completed run whose length L satisfies `short_min` <= L <= `short_max` produces `sym_valid` together with `edge_tick`, with `sym_long` = 0 and `sym_code` = {level of the run, 1'b0}. The codes are 2'b00 for a short low and 2'b10 for a short high.
- R4: A completed run that is not short and satisfies `long_min` <= L <= `long_max` produces `sym_valid` with `sym_long` = 1 and `sym_code` = {level, 1'b1}. The codes are 2'b01 for a long low and 2'b11 for a long high.
- R5: A completed run that lies in neither window produces no `sym_valid` and sets `run_err`. `run_err` stays set until reset.
- R6: The windows follow the threshold inputs, with both ends inclusive. When the two windows overlap, the short decision wins.
- R7: The run counter saturates at 2^CNT_W-1. A run longer than that is measured as 2^CNT_W-1 and never wraps back into a window.
- R8: The first transition after reset ends a run of unknown length. It gives `edge_tick` but neither a symbol nor an error.
- R9: `sym_code` and `sym_long` keep their values until the next `sym_valid`.
- R10: During reset and until the first transition has passed through, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Manchester line, hard decision, asynchronous |
| short_min | input | CNT_W | Lowest run length classed as short |
| short_max | input | CNT_W | Highest run length classed as short |
| long_min | input | CNT_W | Lowest run length classed as long |
| long_max | input | CNT_W | Highest run length classed as long |
| edge_tick | output | 1 | One-cycle strobe per line transition |
| sym_valid | output | 1 | A classified symbol is present this cycle |
| sym_code | output | 2 | {run level, long flag} of the last symbol |
| sym_long | output | 1 | Short (0) or long (1) part of the last symbol |
| run_err | output | 1 | Sticky flag: a run fell outside both windows |

## Verification
The assertions assume that the threshold inputs stay constant while a run is being counted, and that `line_in` is settled at each sampling edge. Under those assumptions the tick can be tied to the line value three and four samples back. The stimulus changes `line_in` only on the falling clock edge. It also changes the thresholds only while reset is held. Each scenario starts from a fresh reset, so the sticky error and the unknown first run are seen from a known starting point.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [1:0] {
    SYM_SHORT_LO = 2'b00,
    SYM_LONG_LO  = 2'b01,
    SYM_SHORT_HI = 2'b10,
    SYM_LONG_HI  = 2'b11
  } sym_e;

  typedef enum logic [1:0] {
    RUN_UNKNOWN = 2'd0,
    RUN_SHORT   = 2'd1,
    RUN_LONG    = 2'd2,
    RUN_BAD     = 2'd3
  } run_kind_e;

  function automatic sym_e make_sym(input logic level, input logic is_long);
    return sym_e'({level, is_long});
  endfunction
endpackage

// File: rtl/mrc_line_sync.sv
module mrc_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level_now,
  output logic level_prev,
  output logic edge_seen
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= line_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign level_now  = stage_q[SYNC_STAGES-1];
  assign level_prev = prev_q;
  assign edge_seen  = level_now ^ prev_q;
endmodule

// File: rtl/mrc_run_counter.sv
module mrc_run_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_seen,
  output logic [CNT_W-1:0] run_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // Zero marks an unknown length, so the count stays there until the first edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (edge_seen) begin
      cnt_q <= CNT_ONE;
    end else if (cnt_q != '0 && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign run_len = cnt_q;
endmodule

// File: rtl/mrc_window_classify.sv
module mrc_window_classify
  import mrc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] run_len,
  input  logic [CNT_W-1:0] short_min,
  input  logic [CNT_W-1:0] short_max,
  input  logic [CNT_W-1:0] long_min,
  input  logic [CNT_W-1:0] long_max,
  output run_kind_e        kind
);
  logic in_short;
  logic in_long;

  assign in_short = (run_len >= short_min) && (run_len <= short_max);
  assign in_long  = (run_len >= long_min)  && (run_len <= long_max);

  always_comb begin
    if (run_len == '0)  kind = RUN_UNKNOWN;
    else if (in_short)  kind = RUN_SHORT;
    else if (in_long)   kind = RUN_LONG;
    else                kind = RUN_BAD;
  end
endmodule

// File: rtl/manchester_run_classifier.sv
module manchester_run_classifier
  import mrc_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic [CNT_W-1:0] short_min,
  input  logic [CNT_W-1:0] short_max,
  input  logic [CNT_W-1:0] long_min,
  input  logic [CNT_W-1:0] long_max,
  output logic             edge_tick,
  output logic             sym_valid,
  output logic [1:0]       sym_code,
  output logic             sym_long,
  output logic             run_err
);
  logic             level_now;
  logic             level_prev;
  logic             edge_seen;
  logic [CNT_W-1:0] run_len;
  run_kind_e        kind;
  logic             emit;
  logic             bad;

  mrc_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .level_now  (level_now),
    .level_prev (level_prev),
    .edge_seen  (edge_seen)
  );

  mrc_run_counter #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_seen (edge_seen),
    .run_len   (run_len)
  );

  mrc_window_classify #(.CNT_W(CNT_W)) u_class (
    .run_len   (run_len),
    .short_min (short_min),
    .short_max (short_max),
    .long_min  (long_min),
    .long_max  (long_max),
    .kind      (kind)
  );

  assign emit = edge_seen && (kind == RUN_SHORT || kind == RUN_LONG);
  assign bad  = edge_seen && (kind == RUN_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_tick <= 1'b0;
      sym_valid <= 1'b0;
      sym_code  <= 2'b00;
      sym_long  <= 1'b0;
      run_err   <= 1'b0;
    end else begin
      edge_tick <= edge_seen;
      sym_valid <= emit;
      if (emit) begin
        sym_code <= make_sym(level_prev, kind == RUN_LONG);
        sym_long <= (kind == RUN_LONG);
      end
      if (bad) run_err <= 1'b1;
    end
  end
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
  parameter int CNT_W = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_in,
  input logic       edge_tick,
  input logic       sym_valid,
  input logic [1:0] sym_code,
  input logic       sym_long
  ,input logic      run_err
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 3'd0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_VALID_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> edge_tick); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run_err |=> run_err); // R5

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> $stable(sym_code) && $stable(sym_long)); // R9

  AST_TICK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5) |-> (edge_tick == ($past(line_in, 3) != $past(line_in, 4)))); // R1

  AST_LONG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (sym_long == sym_code[0])); // R4
endmodule

bind manchester_run_classifier mrc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_in   (line_in),
  .edge_tick (edge_tick),
  .sym_valid (sym_valid),
  .sym_code  (sym_code),
  .sym_long  (sym_long),
  .run_err   (run_err)
);

// File: tb/manchester_run_classifier_test.sv
`timescale 1ns/1ps
module manchester_run_classifier_test;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line_in = 1'b0;
  logic [CNT_W-1:0] short_min, short_max, long_min, long_max;
  logic             edge_tick, sym_valid, sym_long, run_err;
  logic [1:0]       sym_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  manchester_run_classifier #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .short_min(short_min), .short_max(short_max),
    .long_min(long_min), .long_max(long_max),
    .edge_tick(edge_tick), .sym_valid(sym_valid), .sym_code(sym_code),
    .sym_long(sym_long), .run_err(run_err)
  );

  typedef struct {
    bit       tick;
    bit       valid;
    bit [1:0] code;
    bit       lng;
    bit       err;
  } exp_t;

  exp_t q[$];
  bit   m_level;
  int   m_len;
  bit [1:0] m_code;
  bit   m_long;
  bit   m_err;

  function automatic exp_t zero_exp();
    exp_t e;
    e.tick = 0; e.valid = 0; e.code = 0; e.lng = 0; e.err = 0;
    return e;
  endfunction

  // Reference model: one entry per sample, visible two clocks later (R1).
  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = 0; m_len = 0; m_code = 0; m_long = 0; m_err = 0;
      q.delete();
      q.push_back(zero_exp());
      q.push_back(zero_exp());
    end else begin
      exp_t e;
      e = zero_exp();
      if (line_in != m_level) begin
        e.tick = 1;
        if (m_len != 0) begin // R8: unknown first run gives nothing
          if (m_len >= short_min && m_len <= short_max) begin // R6 short first
            e.valid = 1; m_code = {m_level, 1'b0}; m_long = 0;
          end else if (m_len >= long_min && m_len <= long_max) begin
            e.valid = 1; m_code = {m_level, 1'b1}; m_long = 1;
          end else begin
            m_err = 1;
          end
        end
        m_level = line_in;
        m_len = 1;
      end else if (m_len != 0 && m_len < CMAX) begin
        m_len++; // R7 saturation
      end
      e.code = m_code; e.lng = m_long; e.err = m_err;
      q.push_back(e);
    end
  end

  task automatic check1(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 2) begin
      exp_t e;
      e = q.pop_front();
      check1("R2 edge_tick", edge_tick, e.tick);
      check1("R3 R4 sym_valid", sym_valid, e.valid);
      check1("R9 sym_code", sym_code, e.code);
      check1("R9 sym_long", sym_long, e.lng);
      check1("R5 run_err", run_err, e.err);
    end
  end

  task automatic do_reset(input int smin, input int smax, input int lmin, input int lmax);
    @(negedge clk);
    rst_n = 0;
    line_in = 0;
    short_min = CNT_W'(smin); short_max = CNT_W'(smax);
    long_min = CNT_W'(lmin);  long_max = CNT_W'(lmax);
    repeat (3) @(negedge clk);
    // R10: reset state
    check1("R10 reset edge_tick", edge_tick, 0);
    check1("R10 reset sym_valid", sym_valid, 0);
    check1("R10 reset code", {sym_code, sym_long, run_err}, 0);
    rst_n = 1;
  endtask

  task automatic hold(input bit lvl, input int len);
    line_in = lvl;
    repeat (len) @(negedge clk);
  endtask

  // Alternating runs, the first toggles away from the current level.
  task automatic runs(input int lens[]);
    foreach (lens[i]) hold(~line_in, lens[i]);
  endtask

  // Manchester stream at 16.5 samples per bit: one = low then high.
  task automatic stream(input int nbits, input int seed);
    int k = 0;
    int s = seed;
    for (int b = 0; b < nbits; b++) begin
      bit bitv;
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      bitv = s[16];
      for (int h = 0; h < 2; h++) begin
        int d = ((k + 1) * 33) / 4 - (k * 33) / 4;
        hold(h == 0 ? ~bitv : bitv, d);
        k++;
      end
    end
  endtask

  initial begin
    // Main stream with default windows, rational samples per bit (R3 R4 R8)
    do_reset(4, 11, 12, 20);
    hold(0, 10);
    stream(60, 7);
    stream(40, 99);
    // Window edges: 4, 11, 12, 20 (R6)
    do_reset(4, 11, 12, 20);
    hold(0, 6);
    runs('{8, 4, 11, 12, 20, 8, 8});
    // Too short run sets sticky error (R5)
    do_reset(4, 11, 12, 20);
    runs('{8, 8, 3, 8, 8, 16, 8});
    do_reset(4, 11, 12, 20);
    runs('{8, 21, 8, 8});
    // Idle past the counter range: 72 must not wrap to 8 (R7)
    do_reset(4, 11, 12, 20);
    runs('{8, 8, 72, 8, 8});
    // Reprogrammed windows with a gap at 7..8 (R6)
    do_reset(3, 6, 9, 13);
    runs('{5, 3, 6, 9, 13, 5, 7, 5});
    // Overlapping windows: 11 is short (R6)
    do_reset(4, 12, 10, 20);
    runs('{8, 11, 10, 13, 20, 8});
    // Runs of one sample: ticks every cycle, first transition silent (R2 R8)
    do_reset(1, 2, 3, 5);
    runs('{1, 1, 2, 1, 3, 5, 1});
    hold(line_in, 4);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule